// File: doc/BRIEF.md
# Nibble Prefix Instruction Decoder

This block turns a stream of one-byte instructions into complete decoded instructions. In each byte the upper four bits choose one of sixteen function codes and the lower four bits carry a small immediate. A wide operand is built across several bytes. Two of the function codes are prefixes. A prefix merges its nibble into an internal operand register and moves the result up by four bits, so that the next byte's nibble lands in the vacated low bits. One prefix inverts the register before the move, which lets a short chain build negative constants.

Any other function code completes an instruction. The operate code does not emit a primary function. It emits the accumulated operand as the opcode of a zero-operand secondary instruction, which gives an opcode space with no fixed upper bound. Every other code emits a primary instruction with its function code and full operand. The operand register returns to zero after each completed instruction. An operand below 16 therefore needs a single byte and no prefix.

Bytes arrive with a valid strobe. Each decoded instruction appears as a one-cycle pulse on the registered output, one clock after its final byte is accepted.

Top module: `nibble_prefix_decoder`

## Requirements
- R1: After reset `out_valid` is 0 and the operand register is 0. A byte 0x4n that arrives first after reset therefore yields operand n, even if reset cut a prefix chain short.
- R2: A byte whose upper nibble is neither 0x2, 0x6 nor 0xF completes a primary instruction. On the next clock `out_valid` is 1 for one cycle, `out_secondary` is 0, `out_fn` equals the byte's upper nibble, and `out_operand` equals (operand register OR low nibble). With an empty register this is the low nibble zero-extended.
- R3: A byte with upper nibble 0x2 produces no output. The operand register becomes (register OR low nibble) shifted left by 4.
- R4: A byte with upper nibble 0x6 produces no output. The operand register becomes the bitwise inverse of (register OR low nibble), shifted left by 4. For example, 0x60 followed by 0x4F yields operand 0xFFFFFFFF.
- R5: A byte with upper nibble 0xF raises `out_valid` for one cycle with `out_secondary` = 1 and `out_fn` = 0xF. `out_operand` carries the secondary opcode, which is (register OR low nibble). For example, 0x21 followed by 0xF0 gives opcode 0x10.
- R6: After every completed instruction, primary or operate, the operand register is 0. The next instruction starts with a fresh operand.
- R7: The operand register is 32 bits wide. Bits shifted past bit 31 are dropped without any indication. For example, nine 0x2F bytes followed by 0x4F give 0xFFFFFFFF.
- R8: While `in_valid` is 0 the input byte is ignored. `out_valid` stays 0 on the next clock and the operand register keeps its value, so a chain may pause for any number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction byte present this cycle |
| in_byte | input | 8 | Instruction byte: function in 7:4, immediate in 3:0 |
| out_valid | output | 1 | One-cycle pulse per decoded instruction |
| out_secondary | output | 1 | 1 = secondary (operate) instruction, 0 = primary |
| out_fn | output | 4 | Primary function code (0xF for secondary) |
| out_operand | output | OPND_W (32) | Full operand, or the secondary opcode |

## Verification
The hardest states to reach from the ports are long prefix chains that mix both prefix kinds, overflow the 32-bit register, and are broken by idle cycles or a reset in the middle. Uniform random bytes rarely produce them. The random stimulus therefore favours the two prefix codes over the other fourteen and drops the valid strobe on some cycles. Directed sequences add a nine-prefix overflow, a reset in mid-chain, and an operate with a multi-nibble opcode. A bench model computes the expected operand with multiply and subtract arithmetic rather than shifts and inversion.

// File: rtl/npd_pkg.sv
`timescale 1ns/1ps
package npd_pkg;
  localparam int NIB_W  = 4;
  localparam int BYTE_W = 2 * NIB_W;

  typedef enum logic [1:0] {
    KIND_PRIMARY = 2'd0,
    KIND_PFX_POS = 2'd1,
    KIND_PFX_NEG = 2'd2,
    KIND_OPERATE = 2'd3
  } kind_e;

  function automatic logic kind_is_prefix(input kind_e k);
    return (k == KIND_PFX_POS) || (k == KIND_PFX_NEG);
  endfunction
endpackage

// File: rtl/npd_classify.sv
`timescale 1ns/1ps
module npd_classify
  import npd_pkg::*;
#(
  parameter logic [NIB_W-1:0] CODE_PFX_POS = 4'h2,
  parameter logic [NIB_W-1:0] CODE_PFX_NEG = 4'h6,
  parameter logic [NIB_W-1:0] CODE_OPERATE = 4'hF
) (
  input  logic [BYTE_W-1:0] byte_i,
  output logic [NIB_W-1:0]  fn_o,
  output logic [NIB_W-1:0]  nib_o,
  output kind_e             kind_o
);
  assign fn_o  = byte_i[BYTE_W-1:NIB_W];
  assign nib_o = byte_i[NIB_W-1:0];

  always_comb begin
    if (fn_o == CODE_PFX_POS)      kind_o = KIND_PFX_POS;
    else if (fn_o == CODE_PFX_NEG) kind_o = KIND_PFX_NEG;
    else if (fn_o == CODE_OPERATE) kind_o = KIND_OPERATE;
    else                           kind_o = KIND_PRIMARY;
  end
endmodule

// File: rtl/npd_operand_acc.sv
`timescale 1ns/1ps
module npd_operand_acc
  import npd_pkg::*;
#(
  parameter int OPND_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  kind_e             kind_i,
  input  logic [NIB_W-1:0]  nib_i,
  output logic [OPND_W-1:0] acc_o,
  output logic [OPND_W-1:0] merged_o
);
  localparam int PAD_W = OPND_W - NIB_W;

  function automatic logic [OPND_W-1:0] merge_nib(input logic [OPND_W-1:0] a,
                                                  input logic [NIB_W-1:0]  n);
    return a | {{PAD_W{1'b0}}, n};
  endfunction

  function automatic logic [OPND_W-1:0] shift_up(input logic [OPND_W-1:0] x);
    return x << NIB_W;
  endfunction

  logic [OPND_W-1:0] acc_q;
  logic [OPND_W-1:0] acc_d;

  assign merged_o = merge_nib(acc_q, nib_i);

  always_comb begin
    unique case (kind_i)
      KIND_PFX_POS: acc_d = shift_up(merged_o);
      KIND_PFX_NEG: acc_d = shift_up(~merged_o);
      default:      acc_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      acc_q <= '0;
    else if (take_i) acc_q <= acc_d;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/npd_issue.sv
`timescale 1ns/1ps
module npd_issue
  import npd_pkg::*;
#(
  parameter int OPND_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire_i,
  input  kind_e             kind_i,
  input  logic [NIB_W-1:0]  fn_i,
  input  logic [OPND_W-1:0] value_i,
  output logic              valid_o,
  output logic              secondary_o,
  output logic [NIB_W-1:0]  fn_o,
  output logic [OPND_W-1:0] operand_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o     <= 1'b0;
      secondary_o <= 1'b0;
      fn_o        <= '0;
      operand_o   <= '0;
    end else begin
      valid_o <= fire_i;
      if (fire_i) begin
        secondary_o <= (kind_i == KIND_OPERATE);
        fn_o        <= fn_i;
        operand_o   <= value_i;
      end
    end
  end
endmodule

// File: rtl/nibble_prefix_decoder.sv
`timescale 1ns/1ps
module nibble_prefix_decoder
  import npd_pkg::*;
#(
  parameter int OPND_W = 32,
  parameter logic [NIB_W-1:0] CODE_PFX_POS = 4'h2,
  parameter logic [NIB_W-1:0] CODE_PFX_NEG = 4'h6,
  parameter logic [NIB_W-1:0] CODE_OPERATE = 4'hF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  output logic              out_valid,
  output logic              out_secondary,
  output logic [3:0]        out_fn,
  output logic [OPND_W-1:0] out_operand
);
  logic [NIB_W-1:0]  fn;
  logic [NIB_W-1:0]  nib;
  kind_e             kind;
  logic [OPND_W-1:0] acc_q;
  logic [OPND_W-1:0] merged;
  logic              ev_prefix;
  logic              ev_complete;

  npd_classify #(
    .CODE_PFX_POS(CODE_PFX_POS),
    .CODE_PFX_NEG(CODE_PFX_NEG),
    .CODE_OPERATE(CODE_OPERATE)
  ) i_classify (
    .byte_i(in_byte),
    .fn_o  (fn),
    .nib_o (nib),
    .kind_o(kind)
  );

  assign ev_prefix   = in_valid &&  kind_is_prefix(kind);
  assign ev_complete = in_valid && !kind_is_prefix(kind);

  npd_operand_acc #(.OPND_W(OPND_W)) i_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .take_i  (in_valid),
    .kind_i  (kind),
    .nib_i   (nib),
    .acc_o   (acc_q),
    .merged_o(merged)
  );

  npd_issue #(.OPND_W(OPND_W)) i_issue (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire_i     (ev_complete),
    .kind_i     (kind),
    .fn_i       (fn),
    .value_i    (merged),
    .valid_o    (out_valid),
    .secondary_o(out_secondary),
    .fn_o       (out_fn),
    .operand_o  (out_operand)
  );
endmodule

// File: rtl/npd_checker.sv
`timescale 1ns/1ps
module npd_checker #(
  parameter int OPND_W = 32,
  parameter logic [3:0] CODE_OPERATE = 4'hF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [7:0]        in_byte,
  input logic              out_valid,
  input logic              out_secondary,
  input logic [3:0]        out_fn,
  input logic [OPND_W-1:0] out_operand,
  input logic [OPND_W-1:0] acc_q,
  input logic              ev_prefix,
  input logic              ev_complete
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(acc_q)); // R8
  AST_PREFIX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_prefix |=> !out_valid); // R3
  AST_PREFIX_LOW_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    ev_prefix |=> (acc_q[3:0] == 4'h0)); // R4
  AST_COMPLETE_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    ev_complete |=> out_valid); // R2
  AST_COMPLETE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_complete |=> (acc_q == '0)); // R6
  AST_OPERATE_SECONDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_complete && in_byte[7:4] == CODE_OPERATE) |=> out_secondary); // R5
  AST_PRIMARY_FN: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_complete && in_byte[7:4] != CODE_OPERATE) |=>
      (!out_secondary && out_fn == $past(in_byte[7:4]))); // R2
  AST_SHORT_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_complete && acc_q == '0) |=>
      (out_operand == {{(OPND_W-4){1'b0}}, $past(in_byte[3:0])})); // R2
endmodule

bind nibble_prefix_decoder npd_checker #(
  .OPND_W(OPND_W),
  .CODE_OPERATE(CODE_OPERATE)
) i_npd_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_byte      (in_byte),
  .out_valid    (out_valid),
  .out_secondary(out_secondary),
  .out_fn       (out_fn),
  .out_operand  (out_operand),
  .acc_q        (acc_q),
  .ev_prefix    (ev_prefix),
  .ev_complete  (ev_complete)
);

// File: tb/test_nibble_prefix_decoder.sv
`timescale 1ns/1ps
module test_nibble_prefix_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic        out_valid;
  logic        out_secondary;
  logic [3:0]  out_fn;
  logic [31:0] out_operand;

  int unsigned n_checks = 0;
  int unsigned n_fail = 0;
  bit          done = 1'b0;
  logic [31:0] m_acc = 32'h0;

  always #2 clk = ~clk;

  nibble_prefix_decoder i_nibble_prefix_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .out_valid(out_valid), .out_secondary(out_secondary),
    .out_fn(out_fn), .out_operand(out_operand)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Model: prefix 2 -> (acc|n)*16, prefix 6 -> (max-(acc|n))*16, 0xF secondary
  function automatic logic [31:0] m_join(input logic [31:0] a, input logic [3:0] n);
    return a | {28'h0, n};
  endfunction

  task automatic apply(input bit v, input logic [7:0] b, input string req);
    bit          exp_v = 1'b0;
    bit          exp_sec = 1'b0;
    logic [3:0]  exp_fn = b[7:4];
    logic [31:0] exp_op = 32'h0;
    if (v) begin
      exp_op = m_join(m_acc, b[3:0]);
      if (b[7:4] == 4'h2)      m_acc = 32'(exp_op * 32'd16);
      else if (b[7:4] == 4'h6) m_acc = 32'((32'hFFFF_FFFF - exp_op) * 32'd16);
      else begin
        exp_v = 1'b1;
        exp_sec = (b[7:4] == 4'hF);
        m_acc = 32'h0;
      end
    end
    in_valid = v;
    in_byte  = b;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == exp_v, req, "out_valid", {31'h0, out_valid}, {31'h0, exp_v});
    if (exp_v) begin
      check(out_secondary == exp_sec, req, "out_secondary",
            {31'h0, out_secondary}, {31'h0, exp_sec});
      check(out_fn == exp_fn, req, "out_fn", {28'h0, out_fn}, {28'h0, exp_fn});
      check(out_operand == exp_op, req, "out_operand", out_operand, exp_op);
    end
  endtask

  task automatic expect_last(input logic [31:0] op, input bit sec, input string req);
    check(out_operand == op, req, "directed operand", out_operand, op);
    check(out_secondary == sec, req, "directed kind", {31'h0, out_secondary}, {31'h0, sec});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int unsigned r;
    r = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid in reset", {31'h0, out_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after reset", {31'h0, out_valid}, 32'h0);

    // R2: single-byte load of 7
    apply(1'b1, 8'h47, "R2");
    expect_last(32'h7, 1'b0, "R2");
    // R3: two positive prefixes build 0x123
    apply(1'b1, 8'h21, "R3");
    apply(1'b1, 8'h22, "R3");
    apply(1'b1, 8'h43, "R3");
    expect_last(32'h123, 1'b0, "R3");
    // R4: negative prefix then 0x4F gives -1
    apply(1'b1, 8'h60, "R4");
    apply(1'b1, 8'h4F, "R4");
    expect_last(32'hFFFF_FFFF, 1'b0, "R4");
    // R4: negative prefix 0x60, 0x48 gives -8
    apply(1'b1, 8'h60, "R4");
    apply(1'b1, 8'h48, "R4");
    expect_last(32'hFFFF_FFF8, 1'b0, "R4");
    // R5: operate with opcode 0x10
    apply(1'b1, 8'h21, "R5");
    apply(1'b1, 8'hF0, "R5");
    expect_last(32'h10, 1'b1, "R5");
    check(out_fn == 4'hF, "R5", "operate fn", {28'h0, out_fn}, 32'hF);
    // R6: operand cleared after operate
    apply(1'b1, 8'h75, "R6");
    expect_last(32'h5, 1'b0, "R6");
    // R7: nine prefixes overflow the register
    for (int i = 0; i < 9; i++) apply(1'b1, 8'h2F, "R7");
    apply(1'b1, 8'h4F, "R7");
    expect_last(32'hFFFF_FFFF, 1'b0, "R7");
    // R8: idle cycles inside a chain are ignored
    apply(1'b1, 8'h21, "R8");
    apply(1'b0, 8'h4F, "R8");
    apply(1'b0, 8'h6F, "R8");
    apply(1'b1, 8'h22, "R8");
    apply(1'b0, 8'hFF, "R8");
    apply(1'b1, 8'h43, "R8");
    expect_last(32'h123, 1'b0, "R8");
    // R1: reset in mid-chain discards the partial operand
    apply(1'b1, 8'h2F, "R1");
    apply(1'b1, 8'h6A, "R1");
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    m_acc = 32'h0;
    apply(1'b1, 8'h45, "R1");
    expect_last(32'h5, 1'b0, "R1");

    // Random stimulus biased toward prefix chains (R2..R8)
    for (int k = 0; k < 4000; k++) begin
      int unsigned sel = $urandom_range(0, 99);
      logic [3:0] f;
      bit v = ($urandom_range(0, 99) < 85);
      if (sel < 40)      f = 4'h2;
      else if (sel < 55) f = 4'h6;
      else if (sel < 68) f = 4'hF;
      else               f = 4'($urandom_range(0, 15));
      if (v) apply(1'b1, {f, 4'($urandom_range(0, 15))}, "R6");
      else   apply(1'b0, {f, 4'($urandom_range(0, 15))}, "R8");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule